// File: doc/BRIEF.md
# Non-Maskable Interrupt Request Controller

This block gathers the non-maskable interrupt requests of a processor core and hands the core one request at a time, tagged with a 1-bit source code. One source is an external pin. The pin is synchronised and then passed through an edge detector whose rising and falling sensitivity are chosen by two enable inputs. The other source is a watchdog overflow strobe, which counts only while a watchdog mode input is 1. The block has no mask and no priority input. Nothing in the maskable interrupt system can hold its request back, and the core is expected to take it ahead of any maskable request.

The block keeps an in-service flag. The flag is set on the clock edge where the core acknowledges a request. It is cleared only by a return-from-interrupt strobe. Requests that arrive while a request is presented or under service go into a single pending slot, so any number of them collapses into one. That one request is presented on the cycle after the return clears the flag. When both sources fire, or have fired, together, the pin is served first.

Top module: `nmi_ctrl`

## Requirements
- R1: After a synchronous reset, `req` and `in_svc` are 0 and no request is pending. The pin history is cleared, so a pin held at 0 raises nothing afterwards.
- R2: With `rise_en`=1, a 0-to-1 change on `nmi_pin` raises `req` with `req_src`=0 (0 means pin). `req` is visible after the third rising clock edge following the change and not after the second.
- R3: With `fall_en`=1, a 1-to-0 change raises `req` with the same latency as R2. With both enables set, both kinds of edge raise requests. An edge whose enable is 0 raises nothing.
- R4: With `wdt_nmi_mode`=1, a one-cycle `wdt_ovf` pulse raises `req` with `req_src`=1 (1 means watchdog) after the next clock edge. With `wdt_nmi_mode`=0 the pulse has no effect.
- R5: Once raised, `req` and `req_src` hold until `ack` is 1 on a clock edge. On that edge `req` falls and `in_svc` rises.
- R6: While `in_svc` is 1, `req` stays 0. Only a `reti` pulse clears `in_svc`. `ack` without a presented request has no effect.
- R7: Any number of requests from either source arriving during one service period is presented as exactly one request. It is presented one clock edge after the edge on which `reti` clears `in_svc`. After that request has been serviced, no further request follows.
- R8: If the pin and the watchdog events reach the block on the same cycle while it is idle, the pin request (`req_src`=0) is presented first. The watchdog request is presented after the pin request's service ends.
- R9: When the merged pending request includes at least one pin event, it reports `req_src`=0. Otherwise it reports 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| rise_en | input | 1 | Enable detection of rising pin edges |
| fall_en | input | 1 | Enable detection of falling pin edges |
| wdt_ovf | input | 1 | Watchdog overflow strobe, one cycle |
| wdt_nmi_mode | input | 1 | 1: watchdog overflow is a non-maskable request |
| ack | input | 1 | Core acknowledge, one cycle |
| reti | input | 1 | Return-from-interrupt strobe, one cycle |
| req | output | 1 | Request presented to the core |
| req_src | output | 1 | Source of the presented request: 0 pin, 1 watchdog |
| in_svc | output | 1 | In-service flag |

## Verification
A pending slot that is lost or wrongly duplicated shows at `req` one cycle after `reti`: either `req` stays low or it returns after the merged request has been served. A stuck in-service flag shows the same way, because `req` cannot rise again until the flag clears. A wrong source choice shows directly on `req_src` when the request is presented. Broken edge logic shows up within three cycles of a pin change, as a missing request or an unwanted one.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_WDT = 1'b1
  } nmi_src_e;

  // Edge qualification: compares the previous and current synchronised level.
  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic rise_en, input logic fall_en);
    return (rise_en & ~prev & cur) | (fall_en & prev & ~cur);
  endfunction

  // Source of a merged pending slot: a pin event anywhere in the merge wins.
  function automatic nmi_src_e merge_src(input logic held_valid, input nmi_src_e held_src,
                                         input logic pin_ev);
    if (pin_ev || (held_valid && held_src == SRC_PIN)) return SRC_PIN;
    return SRC_WDT;
  endfunction

endpackage

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_en,
  input  logic fall_en,
  output logic edge_ev
);
  import nmi_ctrl_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stage_q;
  logic          hist_q;
  logic          level;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign level = stage_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= level;
  end

  assign edge_ev = edge_hit(hist_q, level, rise_en, fall_en);

endmodule

// File: rtl/nmi_wdt_gate.sv
module nmi_wdt_gate (
  input  logic wdt_ovf,
  input  logic wdt_nmi_mode,
  output logic wdt_ev
);
  assign wdt_ev = wdt_ovf & wdt_nmi_mode;
endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic ev_pin,
  input  logic ev_wdt,
  input  logic ack,
  input  logic reti,
  output logic req,
  output logic req_src,
  output logic in_svc,
  output logic can_present
);
  import nmi_ctrl_pkg::*;

  logic     req_q,  req_n;
  nmi_src_e rsrc_q, rsrc_n;
  logic     svc_q,  svc_n;
  logic     pend_q, pend_n;
  nmi_src_e psrc_q, psrc_n;
  logic     any_ev;

  assign any_ev      = ev_pin | ev_wdt;
  assign can_present = ~svc_q & ~req_q;

  always_comb begin
    req_n  = req_q;
    rsrc_n = rsrc_q;
    svc_n  = svc_q;
    pend_n = pend_q;
    psrc_n = psrc_q;

    if (ack && req_q) begin
      req_n = 1'b0;
      svc_n = 1'b1;
    end else if (reti && svc_q) begin
      svc_n = 1'b0;
    end

    if (can_present) begin
      if (pend_q) begin
        req_n  = 1'b1;
        rsrc_n = psrc_q;
        pend_n = any_ev;
        psrc_n = merge_src(1'b0, SRC_WDT, ev_pin);
      end else if (ev_pin) begin
        req_n  = 1'b1;
        rsrc_n = SRC_PIN;
        pend_n = ev_wdt;
        psrc_n = SRC_WDT;
      end else if (ev_wdt) begin
        req_n  = 1'b1;
        rsrc_n = SRC_WDT;
      end
    end else if (any_ev) begin
      pend_n = 1'b1;
      psrc_n = merge_src(pend_q, psrc_q, ev_pin);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      rsrc_q <= SRC_PIN;
      svc_q  <= 1'b0;
      pend_q <= 1'b0;
      psrc_q <= SRC_PIN;
    end else begin
      req_q  <= req_n;
      rsrc_q <= rsrc_n;
      svc_q  <= svc_n;
      pend_q <= pend_n;
      psrc_q <= psrc_n;
    end
  end

  assign req     = req_q;
  assign req_src = rsrc_q;
  assign in_svc  = svc_q;

endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_pin,
  input  logic rise_en,
  input  logic fall_en,
  input  logic wdt_ovf,
  input  logic wdt_nmi_mode,
  input  logic ack,
  input  logic reti,
  output logic req,
  output logic req_src,
  output logic in_svc
);

  logic ev_pin;
  logic ev_wdt;
  logic can_present;

  nmi_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_pin_edge (
    .clk     (clk),
    .rst     (rst),
    .pin     (nmi_pin),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .edge_ev (ev_pin)
  );

  nmi_wdt_gate i_wdt_gate (
    .wdt_ovf      (wdt_ovf),
    .wdt_nmi_mode (wdt_nmi_mode),
    .wdt_ev       (ev_wdt)
  );

  nmi_arbiter i_arbiter (
    .clk         (clk),
    .rst         (rst),
    .ev_pin      (ev_pin),
    .ev_wdt      (ev_wdt),
    .ack         (ack),
    .reti        (reti),
    .req         (req),
    .req_src     (req_src),
    .in_svc      (in_svc),
    .can_present (can_present)
  );

endmodule

// File: rtl/nmi_ctrl_chk.sv
module nmi_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic rise_en,
  input logic fall_en,
  input logic wdt_nmi_mode,
  input logic ack,
  input logic reti,
  input logic req,
  input logic req_src,
  input logic in_svc,
  input logic ev_pin,
  input logic ev_wdt,
  input logic can_present
);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(req_src));

  // R5
  ack_enter_chk: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> in_svc && !req);

  // R6
  svc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_svc && !reti |=> in_svc);

  // R6
  no_req_in_svc_chk: assert property (@(posedge clk) disable iff (rst)
    in_svc |-> !req && !can_present);

  // R4
  wdt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !wdt_nmi_mode |-> !ev_wdt);

  // R3
  edge_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_en && !fall_en |-> !ev_pin);

  // R2
  pin_take_chk: assert property (@(posedge clk) disable iff (rst)
    can_present && ev_pin |=> req && !req_src);

endmodule

bind nmi_ctrl nmi_ctrl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .rise_en      (rise_en),
  .fall_en      (fall_en),
  .wdt_nmi_mode (wdt_nmi_mode),
  .ack          (ack),
  .reti         (reti),
  .req          (req),
  .req_src      (req_src),
  .in_svc       (in_svc),
  .ev_pin       (ev_pin),
  .ev_wdt       (ev_wdt),
  .can_present  (can_present)
);

// File: tb/test_nmi_ctrl.sv
module test_nmi_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_pin = 1'b0;
  logic rise_en = 1'b0;
  logic fall_en = 1'b0;
  logic wdt_ovf = 1'b0;
  logic wdt_nmi_mode = 1'b0;
  logic ack = 1'b0;
  logic reti = 1'b0;
  logic req;
  logic req_src;
  logic in_svc;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  nmi_ctrl i_nmi_ctrl (
    .clk          (clk),
    .rst          (rst),
    .nmi_pin      (nmi_pin),
    .rise_en      (rise_en),
    .fall_en      (fall_en),
    .wdt_ovf      (wdt_ovf),
    .wdt_nmi_mode (wdt_nmi_mode),
    .ack          (ack),
    .reti         (reti),
    .req          (req),
    .req_src      (req_src),
    .in_svc       (in_svc)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
  endtask

  // Serve a presented request and return, leaving the block idle.
  task automatic serve();
    pulse_ack();
    pulse_reti();
    step(2);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3); rst = 1'b0; step(4);
    chk("R1", "req after reset", {7'd0, req}, 8'd0);
    chk("R1", "in_svc after reset", {7'd0, in_svc}, 8'd0);
  endtask

  task automatic t_rise();
    rise_en = 1'b1; fall_en = 1'b0;
    nmi_pin = 1'b1;
    step(2);
    chk("R2", "req before third edge", {7'd0, req}, 8'd0);
    step(1);
    chk("R2", "req after third edge", {7'd0, req}, 8'd1);
    chk("R2", "req_src pin", {7'd0, req_src}, 8'd0);
    step(3);
    chk("R5", "req held without ack", {7'd0, req}, 8'd1);
    pulse_ack();
    chk("R5", "req drops on ack", {7'd0, req}, 8'd0);
    chk("R5", "in_svc set on ack", {7'd0, in_svc}, 8'd1);
    pulse_ack();
    step(3);
    chk("R6", "in_svc held without reti", {7'd0, in_svc}, 8'd1);
    chk("R6", "no req in service", {7'd0, req}, 8'd0);
    pulse_reti();
    chk("R6", "reti clears in_svc", {7'd0, in_svc}, 8'd0);
    step(3);
    chk("R7", "nothing pending after single", {7'd0, req}, 8'd0);
  endtask

  task automatic t_fall_and_masked_edge();
    // pin is 1 here; rise only enabled, so the fall must be ignored
    nmi_pin = 1'b0;
    step(5);
    chk("R3", "disabled falling edge ignored", {7'd0, req}, 8'd0);
    rise_en = 1'b0; fall_en = 1'b1;
    nmi_pin = 1'b1;
    step(5);
    chk("R3", "disabled rising edge ignored", {7'd0, req}, 8'd0);
    nmi_pin = 1'b0;
    step(2);
    chk("R3", "fall req before third edge", {7'd0, req}, 8'd0);
    step(1);
    chk("R3", "fall raises req", {7'd0, req}, 8'd1);
    chk("R3", "fall req_src pin", {7'd0, req_src}, 8'd0);
    serve();
    rise_en = 1'b1;
    nmi_pin = 1'b1;
    step(3);
    chk("R3", "both enabled, rise", {7'd0, req}, 8'd1);
    serve();
    nmi_pin = 1'b0;
    step(3);
    chk("R3", "both enabled, fall", {7'd0, req}, 8'd1);
    serve();
  endtask

  task automatic t_wdt();
    wdt_nmi_mode = 1'b0;
    pulse_wdt();
    step(3);
    chk("R4", "strobe ignored with mode 0", {7'd0, req}, 8'd0);
    wdt_nmi_mode = 1'b1;
    pulse_wdt();
    chk("R4", "strobe raises req", {7'd0, req}, 8'd1);
    chk("R4", "req_src watchdog", {7'd0, req_src}, 8'd1);
    serve();
    chk("R4", "idle after service", {7'd0, req}, 8'd0);
  endtask

  task automatic t_collapse();
    // pin is 0, both edge enables set
    pulse_wdt();
    chk("R7", "first req watchdog", {7'd0, req_src}, 8'd1);
    pulse_ack();
    pulse_wdt();
    step(1);
    nmi_pin = 1'b1; step(2);
    nmi_pin = 1'b0; step(2);
    pulse_wdt();
    step(5);
    chk("R7", "no req while in service", {7'd0, req}, 8'd0);
    pulse_reti();
    chk("R7", "req not yet on reti edge", {7'd0, req}, 8'd0);
    step(1);
    chk("R7", "merged req after reti", {7'd0, req}, 8'd1);
    chk("R9", "merged src is pin", {7'd0, req_src}, 8'd0);
    serve();
    step(3);
    chk("R7", "exactly one merged req", {7'd0, req}, 8'd0);

    // watchdog-only merge reports watchdog
    pulse_wdt();
    pulse_ack();
    pulse_wdt(); pulse_wdt();
    pulse_reti();
    step(1);
    chk("R9", "watchdog-only merge src", {7'd0, req_src}, 8'd1);
    chk("R9", "watchdog-only merge req", {7'd0, req}, 8'd1);
    serve();
  endtask

  task automatic t_simultaneous();
    // pin is 0; pin latency 3 edges, watchdog 1 edge: align them
    nmi_pin = 1'b1;
    step(2);
    wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
    chk("R8", "req on coincident events", {7'd0, req}, 8'd1);
    chk("R8", "pin served first", {7'd0, req_src}, 8'd0);
    pulse_ack();
    pulse_reti();
    step(1);
    chk("R8", "watchdog follows", {7'd0, req}, 8'd1);
    chk("R8", "watchdog src", {7'd0, req_src}, 8'd1);
    serve();
    chk("R8", "idle afterwards", {7'd0, req}, 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall_and_masked_edge();
    t_wdt();
    t_collapse();
    t_simultaneous();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule